// File: doc/BRIEF.md
# Receive Byte Queue with Idle Timeout

This block buffers received bytes between a serial receiver and the host processor. The receiver hands over each finished byte with a one-cycle push strobe. The host removes the oldest byte with a pop strobe. In queue mode up to 16 bytes are held. The full interrupt is raised only when every entry is occupied, so the host is interrupted far less often than once per byte. With queue mode off, the path behaves as a single holding register.

Bytes that arrive in a short burst and leave the queue partly filled must still reach the host. An idle timer handles this. It counts bit ticks from the receiver's baud generator, and the character length in bit times is programmed on an input. Once more than four character times pass with no push and no pop while data is waiting, a timeout interrupt is raised. The host can observe the write index, the read index, the fill level and any stored entry at any time, and none of these reads changes the queue.

Top module: `rxq_fifo`

## Requirements
- R1: While reset is active, and after it is released, the fill level, write index and read index are 0, and `irq_full`, `irq_timeout` and `overflow` are low.
- R2: Bytes leave in the order they were pushed. `rd_data` shows the oldest stored byte, and a pop moves it to the next one.
- R3: With `fifo_en`=1 the queue holds 16 bytes. `irq_full` is high exactly when the level is 16.
- R4: A push while full, with no pop in the same cycle, is dropped. Level and contents stay unchanged and `overflow` goes high. `overflow` returns low on the next accepted pop.
- R5: With `fifo_en`=1 and data present but not full, `irq_timeout` rises once the number of `bit_tick` pulses since the last push or pop exceeds 4×`frame_bits`. At exactly 4×`frame_bits` pulses it stays low.
- R6: Each accepted push and each accepted pop restarts the idle count. A pop therefore drops `irq_timeout` in the following cycle.
- R7: `irq_timeout` stays low while the queue is empty or full, however many ticks pass.
- R8: `peek_data` shows the entry at physical slot `peek_idx` (4-bit index). Reading it does not change the level or the indices.
- R9: `wr_idx` and `rd_idx` are 4-bit physical slot indices. Each advances by 1, modulo 16, on an accepted push or pop respectively.
- R10: With `fifo_en`=0 the capacity is one byte. `irq_full` is high while that byte is held, and `irq_timeout` stays low.
- R11: A pop while empty is ignored. Indices and level do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: 16-byte queue, 0: single holding register (change only while empty) |
| frame_bits | input | 4 | Bit times per received character |
| bit_tick | input | 1 | One pulse per bit time |
| push | input | 1 | Receiver delivers `push_data` |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Host removes the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| peek_idx | input | 4 | Slot selected for inspection |
| peek_data | output | 8 | Content of the selected slot |
| wr_idx | output | 4 | Next slot to be written |
| rd_idx | output | 4 | Slot of the oldest byte |
| level | output | 5 | Number of stored bytes |
| irq_full | output | 1 | Queue has no free entry |
| irq_timeout | output | 1 | Data has waited over four character times |
| overflow | output | 1 | A byte was dropped since the last pop |

## Verification
The queue is filled with a rising byte pattern right up to 16 entries and then drained. This separates correct ordering and index wraparound from off-by-one errors in the full flag. An extra push at full separates a dropped byte from an overwritten one. The idle timer is driven with exactly 4×`frame_bits` ticks and then one more, and tick bursts are repeated after a push and after a pop, so the strict comparison and both restart sources are each pinned down. Long tick runs while empty, while full and in holding-register mode show that the timeout is gated by occupancy and mode.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic wr_en;
    logic rd_en;
    logic drop;
  } rxq_ctl_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] pk_addr,
  output logic [DW-1:0] pk_data
);
  logic [DW-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (hit) slot[i] <= wr_data;
    end
  end

  assign rd_data = slot[rd_addr];
  assign pk_data = slot[pk_addr];
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
  import rxq_pkg::*;
#(
  parameter int AW = 4,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] cap,
  output rxq_ctl_t      ctl,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [LW-1:0] cnt,
  output logic          full,
  output logic          ovf
);
  logic [AW-1:0] wr_ptr_nx, rd_ptr_nx;
  logic [LW-1:0] cnt_nx;
  logic          ovf_nx, empty;

  always_comb begin
    full       = (cnt >= cap);
    empty      = (cnt == '0);
    ctl.rd_en  = pop && !empty;
    ctl.wr_en  = push && (!full || ctl.rd_en);
    ctl.drop   = push && !ctl.wr_en;
    wr_ptr_nx  = wr_ptr;
    rd_ptr_nx  = rd_ptr;
    cnt_nx     = cnt;
    ovf_nx     = ovf;
    if (ctl.wr_en) wr_ptr_nx = wr_ptr + 1'b1;
    if (ctl.rd_en) rd_ptr_nx = rd_ptr + 1'b1;
    case ({ctl.wr_en, ctl.rd_en})
      2'b10:   cnt_nx = cnt + 1'b1;
      2'b01:   cnt_nx = cnt - 1'b1;
      default: cnt_nx = cnt;
    endcase
    if (ctl.drop)       ovf_nx = 1'b1;
    else if (ctl.rd_en) ovf_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      cnt    <= cnt_nx;
      ovf    <= ovf_nx;
    end
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int FW = 4,
  parameter int CW = FW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          hold,
  input  logic          tick,
  input  logic [FW-1:0] frame_len,
  output logic          expired
);
  logic [CW-1:0] ticks, ticks_nx;
  logic [CW-1:0] limit;

  always_comb begin
    limit    = CW'({frame_len, 2'b00});
    expired  = (ticks > limit);
    ticks_nx = ticks;
    if (restart || hold)      ticks_nx = '0;
    else if (tick && !expired) ticks_nx = ticks + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ticks <= '0;
    else        ticks <= ticks_nx;
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int FW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [FW-1:0] frame_bits,
  input  logic          bit_tick,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] peek_idx,
  output logic [DW-1:0] peek_data,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic [LW-1:0] level,
  output logic          irq_full,
  output logic          irq_timeout,
  output logic          overflow
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  rxq_ctl_t      ctl;
  logic [LW-1:0] cap;
  logic          full, expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign cap = fifo_en ? LW'(DEPTH) : LW'(1);

  rxq_ptrs #(.AW(AW), .LW(LW)) u_ptrs (
    .clk(clk), .rst_n(rst_int_n), .push(push), .pop(pop), .cap(cap),
    .ctl(ctl), .wr_ptr(wr_idx), .rd_ptr(rd_idx), .cnt(level),
    .full(full), .ovf(overflow)
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .wr_en(ctl.wr_en), .wr_addr(wr_idx), .wr_data(push_data),
    .rd_addr(rd_idx), .rd_data(rd_data), .pk_addr(peek_idx), .pk_data(peek_data)
  );

  rxq_idle_timer #(.FW(FW)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .restart(ctl.wr_en || ctl.rd_en),
    .hold(level == '0), .tick(bit_tick), .frame_len(frame_bits),
    .expired(expired)
  );

  assign irq_full    = full;
  assign irq_timeout = fifo_en && expired && (level != '0) && !full;
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic [AW-1:0] wr_idx,
  input logic [AW-1:0] rd_idx,
  input logic [LW-1:0] level,
  input logic          irq_full,
  input logic          irq_timeout,
  input logic          overflow
);
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && irq_full && !pop) |=> (level == $past(level)) && $stable(wr_idx) && overflow);

  p_restart_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && level != '0) |=> !irq_timeout);

  p_tmo_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timeout |-> (level != '0) && !irq_full);

  p_wr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !irq_full) |=> wr_idx == $past(wr_idx) + 1'b1);

  p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && level == '0 && !push) |=> $stable(rd_idx) && level == '0);
endmodule

bind rxq_fifo rxq_fifo_chk #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wr_idx(wr_idx),
  .rd_idx(rd_idx), .level(level), .irq_full(irq_full),
  .irq_timeout(irq_timeout), .overflow(overflow)
);

// File: tb/rxq_fifo_test.sv
module rxq_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en;
  logic [3:0] frame_bits;
  logic       bit_tick, push, pop;
  logic [7:0] push_data, rd_data, peek_data;
  logic [3:0] peek_idx, wr_idx, rd_idx;
  logic [4:0] level;
  logic       irq_full, irq_timeout, overflow;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rxq_fifo uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .frame_bits(frame_bits),
    .bit_tick(bit_tick), .push(push), .push_data(push_data), .pop(pop),
    .rd_data(rd_data), .peek_idx(peek_idx), .peek_data(peek_data),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .level(level), .irq_full(irq_full),
    .irq_timeout(irq_timeout), .overflow(overflow)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic mode);
    fifo_en = mode; frame_bits = 4'd10; bit_tick = 0; push = 0; pop = 0;
    push_data = 0; peek_idx = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push_byte(logic [7:0] d);
    push = 1; push_data = d;
    @(negedge clk);
    push = 0;
  endtask

  task automatic pop_byte();
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic ticks(int n);
    bit_tick = 1;
    repeat (n) @(negedge clk);
    bit_tick = 0;
  endtask

  task automatic t_reset();
    do_reset(1);
    chk("R1 level", level, 0); chk("R1 wr_idx", wr_idx, 0);
    chk("R1 rd_idx", rd_idx, 0); chk("R1 irq_full", irq_full, 0);
    chk("R1 irq_timeout", irq_timeout, 0); chk("R1 overflow", overflow, 0);
    pop_byte();
    chk("R11 pop empty rd_idx", rd_idx, 0); chk("R11 pop empty level", level, 0);
  endtask

  task automatic t_fill_drain();
    do_reset(1);
    for (int i = 0; i < 15; i++) push_byte(8'hA0 + 8'(i));
    chk("R3 not full at 15", irq_full, 0);
    push_byte(8'hAF);
    chk("R3 full at 16", irq_full, 1); chk("R3 level", level, 16);
    chk("R9 wr_idx wrapped", wr_idx, 0);
    ticks(70);
    chk("R7 no timeout when full", irq_timeout, 0);
    push_byte(8'hFF);
    chk("R4 overflow set", overflow, 1); chk("R4 level kept", level, 16);
    peek_idx = 4'd0; #1;
    chk("R4 slot0 not overwritten", peek_data, 8'hA0);
    peek_idx = 4'd7; #1;
    chk("R8 peek slot7", peek_data, 8'hA7);
    chk("R8 peek keeps level", level, 16); chk("R8 peek keeps rd_idx", rd_idx, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R2 order", rd_data, 8'hA0 + i);
      pop_byte();
      if (i == 0) chk("R4 overflow cleared by pop", overflow, 0);
    end
    chk("R9 rd_idx wrapped", rd_idx, 0); chk("R2 drained", level, 0);
  endtask

  task automatic t_timeout();
    do_reset(1);
    push_byte(8'h11);
    ticks(40);
    chk("R5 no timeout at 4 char times", irq_timeout, 0);
    ticks(1);
    chk("R5 timeout after 4 char times", irq_timeout, 1);
    push_byte(8'h22);
    chk("R6 push restarts", irq_timeout, 0);
    ticks(40);
    chk("R6 still quiet after push", irq_timeout, 0);
    ticks(1);
    chk("R5 timeout again", irq_timeout, 1);
    pop_byte();
    chk("R6 pop clears timeout", irq_timeout, 0); chk("R6 level", level, 1);
    frame_bits = 4'd3;
    ticks(12);
    chk("R5 short frame boundary", irq_timeout, 0);
    ticks(1);
    chk("R5 short frame timeout", irq_timeout, 1);
    pop_byte();
    ticks(60);
    chk("R7 no timeout when empty", irq_timeout, 0);
  endtask

  task automatic t_holding();
    do_reset(0);
    push_byte(8'h5A);
    chk("R10 full with one byte", irq_full, 1); chk("R10 level", level, 1);
    push_byte(8'h33);
    chk("R10 second byte dropped", overflow, 1); chk("R10 level kept", level, 1);
    chk("R10 holds first byte", rd_data, 8'h5A);
    ticks(100);
    chk("R10 no timeout", irq_timeout, 0);
    pop_byte();
    chk("R10 empty after pop", irq_full, 0); chk("R10 level 0", level, 0);
  endtask

  initial begin
    t_reset();
    t_fill_drain();
    t_timeout();
    t_holding();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule